// File: doc/BRIEF.md
# SPI Interrupt Status, Mask and TX Watermark Unit

This unit sits beside the FIFOs and shift engine of an SPI controller. It gathers their conditions into one status word and keeps an interrupt mask that software edits through separate write-only set and clear addresses. It drives a single interrupt line. Conditions that follow FIFO state are passed through live. The mode-fault event is held until software clears it by writing a one to its bit.

A threshold register sets the transmit watermark. The unit reports the watermark condition while the transmit FIFO level is below the programmed threshold. The register is only as wide as the FIFO depth needs, so software can find the depth by writing all ones and reading back. Access is through a plain port with address, write data, write strobe and combinational read data.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset the mask reads 0, the latched fault is clear, the threshold reads 1 and irq_o is low.
- R2: A write to byte address 0x08 sets every mask bit whose write-data bit is 1 and leaves the others unchanged. A read of 0x08 returns 0.
- R3: A write to byte address 0x0C clears every mask bit whose write-data bit is 1 and leaves the others unchanged. A read of 0x0C returns 0.
- R4: Byte address 0x10 returns the 7-bit mask in bits 6:0. A write to 0x10 does not change the mask.
- R5: Byte address 0x04 returns the status word with this layout: bit 1 is mode fault, bit 2 is TX below watermark, bit 3 is TX full and bit 4 is RX not empty. Bits 0, 5, 6 and 31:7 read 0.
- R6: A mode-fault pulse sets status bit 1 at the next clock edge. The bit then stays set until a status write has bit 1 at 1. A status write with bit 1 at 0 leaves it set.
- R7: When a mode-fault pulse and a status write with bit 1 at 1 arrive in the same cycle, status bit 1 is set afterwards.
- R8: Status bits 2, 3 and 4 follow the live inputs in the same cycle. Writing ones to them through 0x04 has no effect.
- R9: A write to byte address 0x28 keeps only the low log2(DEPTH) bits, and a read returns them. With DEPTH=128, writing 0xFFFF reads back 127.
- R10: Status bit 2 is 1 exactly when tx_level_i is less than the threshold.
- R11: irq_o is 1 exactly when some status bit and the matching mask bit are both 1.
- R12: Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (8) | Byte address of the register access |
| wdata_i | input | DATA_W (32) | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | DATA_W (32) | Combinational read data for addr_i |
| tx_level_i | input | $clog2(DEPTH+1) | Transmit FIFO fill level |
| tx_full_i | input | 1 | Transmit FIFO is full |
| rx_nempty_i | input | 1 | Receive FIFO holds at least one word |
| mode_fault_i | input | 1 | One-cycle mode-fault event |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sends a fault pulse and a clearing write in the same cycle. A design that gives the clear priority would lose the event, and bit 1 would read 0. The bench also writes ones and zeros to the status word over the level bits and the latched bit. A design that latches the level bits, or that clears on a written zero, shows stale or vanished status. The threshold is probed at the depth-discovery value and just on either side of it: level 126 and level 127 against threshold 127. An off-by-one compare, or a register wider or narrower than the depth needs, shows up there. The bench enables and disables masks with mixed patterns to catch set and clear logic that disturbs bits written as zero.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned NUM_BITS = 7;

  localparam int unsigned BIT_FAULT = 1;
  localparam int unsigned BIT_TXLOW = 2;
  localparam int unsigned BIT_TXFUL = 3;
  localparam int unsigned BIT_RXNE  = 4;

  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_SET  = 8'h08;
  localparam logic [7:0] A_CLR  = 8'h0C;
  localparam logic [7:0] A_MASK = 8'h10;
  localparam logic [7:0] A_THR  = 8'h28;
endpackage

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [N-1:0] bits_i,
  output logic [N-1:0] mask_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q <= 1'b0;
      else if (set_i && bits_i[g]) q <= 1'b1;
      else if (clr_i && bits_i[g]) q <= 1'b0;
    end
    assign mask_o[g] = q;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fault_i,
  input  logic                clr_i,
  input  logic [NUM_BITS-1:0] clr_bits_i,
  input  logic                tx_low_i,
  input  logic                tx_full_i,
  input  logic                rx_nempty_i,
  output logic [NUM_BITS-1:0] status_o
);
  logic fault_q;

  // new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              fault_q <= 1'b0;
    else if (fault_i)                         fault_q <= 1'b1;
    else if (clr_i && clr_bits_i[BIT_FAULT])  fault_q <= 1'b0;
  end

  always_comb begin
    status_o            = '0;
    status_o[BIT_FAULT] = fault_q;
    status_o[BIT_TXLOW] = tx_low_i;
    status_o[BIT_TXFUL] = tx_full_i;
    status_o[BIT_RXNE]  = rx_nempty_i;
  end
endmodule

// File: rtl/spi_irq_thresh.sv
module spi_irq_thresh #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned THR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [THR_W-1:0] thr_o,
  output logic             below_o
);
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_q <= THR_W'(1);
    else if (we_i) thr_q <= thr_i;
  end

  assign thr_o   = thr_q;
  assign below_o = level_i < LVL_W'(thr_q);
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned THR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic              tx_full_i,
  input  logic              rx_nempty_i,
  input  logic              mode_fault_i,
  output logic              irq_o
);
  logic                hit_stat, hit_set, hit_clr, hit_mask, hit_thr;
  logic [NUM_BITS-1:0] mask_q, status_w;
  logic [THR_W-1:0]    thr_w;
  logic                tx_low_w;
  logic                unused_wdata;

  assign hit_stat = addr_i == ADDR_W'(A_STAT);
  assign hit_set  = addr_i == ADDR_W'(A_SET);
  assign hit_clr  = addr_i == ADDR_W'(A_CLR);
  assign hit_mask = addr_i == ADDR_W'(A_MASK);
  assign hit_thr  = addr_i == ADDR_W'(A_THR);

  assign unused_wdata = ^wdata_i;

  spi_irq_mask #(.N(NUM_BITS)) i_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (we_i && hit_set),
    .clr_i  (we_i && hit_clr),
    .bits_i (wdata_i[NUM_BITS-1:0]),
    .mask_o (mask_q)
  );

  spi_irq_thresh #(.DEPTH(DEPTH)) i_thresh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && hit_thr),
    .thr_i   (wdata_i[THR_W-1:0]),
    .level_i (tx_level_i),
    .thr_o   (thr_w),
    .below_o (tx_low_w)
  );

  spi_irq_status i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fault_i     (mode_fault_i),
    .clr_i       (we_i && hit_stat),
    .clr_bits_i  (wdata_i[NUM_BITS-1:0]),
    .tx_low_i    (tx_low_w),
    .tx_full_i   (tx_full_i),
    .rx_nempty_i (rx_nempty_i),
    .status_o    (status_w)
  );

  always_comb begin
    rdata_o = '0;
    if (hit_stat)      rdata_o = DATA_W'(status_w);
    else if (hit_mask) rdata_o = DATA_W'(mask_q);
    else if (hit_thr)  rdata_o = DATA_W'(thr_w);
  end

  assign irq_o = |(status_w & mask_q);
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic                we_i,
  input logic                mode_fault_i,
  input logic                irq_o,
  input logic [NUM_BITS-1:0] mask_q,
  input logic [NUM_BITS-1:0] status_w
);
  logic wr_set, wr_clr, wr_fclr;
  assign wr_set  = we_i && addr_i == ADDR_W'(A_SET);
  assign wr_clr  = we_i && addr_i == ADDR_W'(A_CLR);
  assign wr_fclr = we_i && addr_i == ADDR_W'(A_STAT) && wdata_i[BIT_FAULT];

  AST_SET_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((mask_q & $past(wdata_i[NUM_BITS-1:0])) == $past(wdata_i[NUM_BITS-1:0]))); // R2
  AST_CLR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((mask_q & $past(wdata_i[NUM_BITS-1:0])) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(mask_q)); // R4
  AST_FAULT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_fault_i |=> status_w[BIT_FAULT]); // R7
  AST_FAULT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_w[BIT_FAULT] && !wr_fclr) |=> status_w[BIT_FAULT]); // R6
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> !irq_o); // R11
endmodule

bind spi_irq_unit spi_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .we_i         (we_i),
  .mode_fault_i (mode_fault_i),
  .irq_o        (irq_o),
  .mask_q       (mask_q),
  .status_w     (status_w)
);

// File: tb/test_spi_irq_unit.sv
`timescale 1ns/1ps
module test_spi_irq_unit;
  localparam int unsigned DEPTH = 128;
  localparam int unsigned LVL_W = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       addr_i = '0;
  logic [31:0]      wdata_i = '0;
  logic             we_i = 1'b0;
  logic [31:0]      rdata_o;
  logic [LVL_W-1:0] tx_level_i = '0;
  logic             tx_full_i = 1'b0;
  logic             rx_nempty_i = 1'b0;
  logic             mode_fault_i = 1'b0;
  logic             irq_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  spi_irq_unit #(.DEPTH(DEPTH)) i_spi_irq_unit (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .tx_level_i, .tx_full_i, .rx_nempty_i, .mode_fault_i, .irq_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h10, d); check("R1 mask", d, 0);
    rd(8'h28, d); check("R1 thr", d, 1);
    rd(8'h04, d); check("R1 status", d, 32'h04); // level 0 < 1
    check("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(8'h08, 32'h0000_0055);
    rd(8'h10, d); check("R2 set", d, 32'h55);
    wr(8'h08, 32'h0000_000A);
    rd(8'h10, d); check("R2 set keeps zeros", d, 32'h5F);
    rd(8'h08, d); check("R2 read zero", d, 0);
    wr(8'h0C, 32'h0000_0041);
    rd(8'h10, d); check("R3 clr", d, 32'h1E);
    rd(8'h0C, d); check("R3 read zero", d, 0);
    wr(8'h10, 32'h0000_007F);
    rd(8'h10, d); check("R4 ro mask", d, 32'h1E);
    wr(8'h0C, 32'h0000_007F);
    rd(8'h10, d); check("R3 clr all", d, 0);
    rd(8'h3C, d); check("R12 unmapped", d, 0);
  endtask

  task automatic t_levels;
    logic [31:0] d;
    tx_level_i = 8'd5; tx_full_i = 1'b1; rx_nempty_i = 1'b1;
    rd(8'h04, d); check("R5 layout", d, 32'h18);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R8 w1c no effect", d, 32'h18);
    tx_full_i = 1'b0;
    rd(8'h04, d); check("R8 live full", d, 32'h10);
    rx_nempty_i = 1'b0;
    rd(8'h04, d); check("R8 live rxne", d, 32'h00);
    tx_level_i = '0;
  endtask

  task automatic t_fault;
    logic [31:0] d;
    tx_level_i = 8'd3;
    @(negedge clk_i); mode_fault_i = 1'b1;
    @(negedge clk_i); mode_fault_i = 1'b0;
    rd(8'h04, d); check("R6 latch", d, 32'h02);
    wr(8'h04, 32'h0000_001D);
    rd(8'h04, d); check("R6 zero write keeps", d, 32'h02);
    @(negedge clk_i); mode_fault_i = 1'b1;
    addr_i = 8'h04; wdata_i = 32'h02; we_i = 1'b1;
    @(negedge clk_i); mode_fault_i = 1'b0; we_i = 1'b0;
    rd(8'h04, d); check("R7 collide", d, 32'h02);
    wr(8'h04, 32'h0000_0002);
    rd(8'h04, d); check("R6 clear", d, 32'h00);
    tx_level_i = '0;
  endtask

  task automatic t_thresh;
    logic [31:0] d;
    wr(8'h28, 32'h0000_FFFF);
    rd(8'h28, d); check("R9 depth probe", d, DEPTH - 1);
    tx_level_i = 8'd126;
    rd(8'h04, d); check("R10 below", d, 32'h04);
    tx_level_i = 8'd127;
    rd(8'h04, d); check("R10 equal", d, 32'h00);
    tx_level_i = 8'd128;
    rd(8'h04, d); check("R10 above", d, 32'h00);
    wr(8'h28, 32'h0000_0184);
    rd(8'h28, d); check("R9 truncate", d, 32'h04);
    tx_level_i = 8'd3;
    rd(8'h04, d); check("R10 small below", d, 32'h04);
    wr(8'h28, 32'h1);
    tx_level_i = 8'd9;
  endtask

  task automatic t_irq;
    tx_full_i = 1'b1;
    #0.5 check("R11 masked off", {31'b0, irq_o}, 0);
    wr(8'h08, 32'h0000_0008);
    #0.5 check("R11 enabled", {31'b0, irq_o}, 1);
    tx_full_i = 1'b0;
    #0.5 check("R11 source gone", {31'b0, irq_o}, 0);
    wr(8'h08, 32'h0000_0002);
    @(negedge clk_i); mode_fault_i = 1'b1;
    @(negedge clk_i); mode_fault_i = 1'b0;
    #0.5 check("R11 fault irq", {31'b0, irq_o}, 1);
    wr(8'h0C, 32'h0000_0002);
    #0.5 check("R11 disabled", {31'b0, irq_o}, 0);
    wr(8'h04, 32'h0000_0002);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mask();
    t_levels();
    t_fault();
    t_thresh();
    t_irq();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule